// File: doc/BRIEF.md
# Two-Pin Bootloader Entry Detector

This block decides, each time the external reset pin is released, whether the device should start its resident bootloader or the normal user program. While reset is held low it counts qualifying transitions on a test/clock pin. At the moment reset rises it looks at the level of that same pin. It also weighs three inhibit conditions: a debugger that owns the device, a power-on reset in progress, and the reset pin being configured as a non-maskable interrupt input. Its answer is one single-cycle pulse, either start-bootloader or start-user.

A parameter selects the polarity. In the rising variant the pin must show rising edges and must be high at release. In the falling variant the pin must show falling edges and must be low at release. In both variants the block also drives an internal test-mode level. This level follows the active level of the pin. It is forced inactive once the qualifying edge count is reached with reset still low, so that the shared pins stay in application mode during an entry sequence.

All inputs are assumed to be already synchronized to the clock. The block has no data stream, so every pin is a plain level or pulse and no back-pressure applies.

Top module: `boot_entry_detect`

## Requirements
- R1: With VARIANT rising, a reset release (rst_pin_i sampled 0 then 1) preceded by at least EDGE_MIN (default 2) rising edges of tst_pin_i while rst_pin_i was low, with tst_pin_i high at the release sample and no inhibit, produces boot_start_o.
- R2: With VARIANT falling, the same holds with falling edges of tst_pin_i, and tst_pin_i must be low at the release sample.
- R3: A release preceded by fewer than EDGE_MIN qualifying edges while reset was low produces user_start_o.
- R4: If tst_pin_i is at its inactive level at the release sample (low for rising, high for falling), the release produces user_start_o.
- R5: If dbg_own_i is high at the release sample, the release produces user_start_o.
- R6: If nmi_mode_i is high at the release sample, the release produces user_start_o.
- R7: While por_i is high, all outputs are 0, the edge count is cleared and edges are ignored. After por_i falls, no decision is made until rst_pin_i has been sampled low.
- R8: Every release produces exactly one pulse, on exactly one of boot_start_o or user_start_o. The pulse is one cycle long and appears in the cycle after the release sample.
- R9: The edge count clears whenever rst_pin_i is high, so edges seen with reset high do not count. The count saturates at EDGE_MIN, so extra edges still allow entry.
- R10: test_mode_o, registered, follows the active level of tst_pin_i. It is forced to 0 from the edge that completes the EDGE_MIN count while rst_pin_i is low, until rst_pin_i is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| rst_pin_i | input | 1 | External reset pin level, low = held in reset |
| tst_pin_i | input | 1 | Test/clock pin level whose edges are counted |
| dbg_own_i | input | 1 | Debug interface owns the device; blocks entry |
| nmi_mode_i | input | 1 | Reset pin configured as NMI input; blocks entry |
| boot_start_o | output | 1 | One-cycle pulse: start the bootloader |
| user_start_o | output | 1 | One-cycle pulse: start the user program |
| test_mode_o | output | 1 | Internal test-mode level for the shared pins |

## Verification
The bound checker watches every cycle for several properties. It checks that the two start pulses are mutually exclusive and last one cycle. It checks that every pulse follows a sampled low-to-high reset transition, and that every such transition outside power-on reset yields a pulse. It also checks that a bootloader pulse never comes with an inhibit set or with the pin at its inactive level, and that test_mode_o is only high after an active pin sample. Some behaviour depends on history that only directed scenarios can show: the exact edge count needed, saturation, edges ignored while reset is high, edges ignored during power-on reset, and the forced-low test mode after the final edge. The bench drives both polarity variants with mirrored stimulus and compares them against a queue of expected decisions.

// File: rtl/boot_entry_pkg.sv
package boot_entry_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_variant_e;

  // Pin level that counts as "active" for a variant.
  function automatic logic active_level(edge_variant_e v);
    return (v == EDGE_RISE);
  endfunction

endpackage

// File: rtl/be_edge_qual.sv
module be_edge_qual
  import boot_entry_pkg::*;
#(
  parameter edge_variant_e VARIANT = EDGE_RISE
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic pin_i,
  output logic edge_o,
  output logic active_o
);
  localparam logic ACT = active_level(VARIANT);

  logic prev_q;

  // Start at the active level so a pin already active at power-up
  // does not count as an edge.
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) prev_q <= ACT;
    else       prev_q <= pin_i;
  end

  generate
    if (VARIANT == EDGE_RISE) begin : g_rise
      assign edge_o = !prev_q && pin_i;
    end else begin : g_fall
      assign edge_o = prev_q && !pin_i;
    end
  endgenerate

  assign active_o = (pin_i == ACT);
endmodule

// File: rtl/be_edge_count.sv
module be_edge_count #(
  parameter int unsigned EDGE_MIN = 2,
  localparam int unsigned CW = $clog2(EDGE_MIN + 1)
) (
  input  logic          clk_i,
  input  logic          por_i,
  input  logic          clr_i,
  input  logic          edge_i,
  output logic [CW-1:0] cnt_o,
  output logic          reached_o,
  output logic          reached_next_o
);
  localparam logic [CW-1:0] LIM = CW'(EDGE_MIN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                      cnt_d = '0;
    else if (edge_i && cnt_q < LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) cnt_q <= '0;
    else       cnt_q <= cnt_d;
  end

  assign cnt_o          = cnt_q;
  assign reached_o      = (cnt_q >= LIM);
  assign reached_next_o = (cnt_d >= LIM);
endmodule

// File: rtl/be_decide.sv
module be_decide (
  input  logic clk_i,
  input  logic por_i,
  input  logic rst_pin_i,
  input  logic active_i,
  input  logic reached_i,
  input  logic reached_next_i,
  input  logic dbg_own_i,
  input  logic nmi_mode_i,
  output logic boot_start_o,
  output logic user_start_o,
  output logic test_mode_o
);
  logic rst_prev_q;
  logic release_w, entry_ok_w, tm_d;
  logic boot_q, user_q, tm_q;

  // Reset value high: a release is only seen after a low sample
  // taken once power-on reset is over.
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) rst_prev_q <= 1'b1;
    else       rst_prev_q <= rst_pin_i;
  end

  assign release_w  = !rst_prev_q && rst_pin_i;
  assign entry_ok_w = reached_i && active_i && !dbg_own_i && !nmi_mode_i;
  assign tm_d       = active_i && !(!rst_pin_i && reached_next_i);

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      boot_q <= 1'b0;
      user_q <= 1'b0;
      tm_q   <= 1'b0;
    end else begin
      boot_q <= release_w && entry_ok_w;
      user_q <= release_w && !entry_ok_w;
      tm_q   <= tm_d;
    end
  end

  assign boot_start_o = boot_q;
  assign user_start_o = user_q;
  assign test_mode_o  = tm_q;
endmodule

// File: rtl/boot_entry_detect.sv
module boot_entry_detect
  import boot_entry_pkg::*;
#(
  parameter edge_variant_e VARIANT  = EDGE_RISE,
  parameter int unsigned   EDGE_MIN = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic rst_pin_i,
  input  logic tst_pin_i,
  input  logic dbg_own_i,
  input  logic nmi_mode_i,
  output logic boot_start_o,
  output logic user_start_o,
  output logic test_mode_o
);
  localparam int unsigned CW = $clog2(EDGE_MIN + 1);

  logic          edge_w, active_w, reached_w, reached_next_w;
  logic [CW-1:0] cnt_w;

  be_edge_qual #(.VARIANT(VARIANT)) u_qual (
    .clk_i    (clk_i),
    .por_i    (por_i),
    .pin_i    (tst_pin_i),
    .edge_o   (edge_w),
    .active_o (active_w)
  );

  be_edge_count #(.EDGE_MIN(EDGE_MIN)) u_count (
    .clk_i          (clk_i),
    .por_i          (por_i),
    .clr_i          (rst_pin_i),
    .edge_i         (edge_w),
    .cnt_o          (cnt_w),
    .reached_o      (reached_w),
    .reached_next_o (reached_next_w)
  );

  be_decide u_decide (
    .clk_i          (clk_i),
    .por_i          (por_i),
    .rst_pin_i      (rst_pin_i),
    .active_i       (active_w),
    .reached_i      (reached_w),
    .reached_next_i (reached_next_w),
    .dbg_own_i      (dbg_own_i),
    .nmi_mode_i     (nmi_mode_i),
    .boot_start_o   (boot_start_o),
    .user_start_o   (user_start_o),
    .test_mode_o    (test_mode_o)
  );

  logic unused_w;
  assign unused_w = ^cnt_w;
endmodule

// File: rtl/be_checker.sv
module be_checker
  import boot_entry_pkg::*;
#(
  parameter edge_variant_e VARIANT = EDGE_RISE
) (
  input logic clk_i,
  input logic por_i,
  input logic rst_pin_i,
  input logic tst_pin_i,
  input logic dbg_own_i,
  input logic nmi_mode_i,
  input logic boot_start_o,
  input logic user_start_o,
  input logic test_mode_o
);
  localparam logic ACT = active_level(VARIANT);

  p_excl_r8: assert property (@(posedge clk_i) disable iff (por_i)
    !(boot_start_o && user_start_o));

  p_one_cycle_r8: assert property (@(posedge clk_i) disable iff (por_i)
    (boot_start_o || user_start_o) |=> !(boot_start_o || user_start_o));

  p_after_release_r8: assert property (@(posedge clk_i) disable iff (por_i)
    (boot_start_o || user_start_o) |-> ($past(rst_pin_i) && !$past(rst_pin_i, 2)));

  p_release_decides_r8: assert property (@(posedge clk_i) disable iff (por_i)
    (!$past(por_i) && $rose(rst_pin_i)) |=> (boot_start_o || user_start_o));

  p_boot_no_dbg_r5: assert property (@(posedge clk_i) disable iff (por_i)
    boot_start_o |-> !$past(dbg_own_i));

  p_boot_no_nmi_r6: assert property (@(posedge clk_i) disable iff (por_i)
    boot_start_o |-> !$past(nmi_mode_i));

  p_boot_level_r4: assert property (@(posedge clk_i) disable iff (por_i)
    boot_start_o |-> ($past(tst_pin_i) == ACT));

  p_tm_level_r10: assert property (@(posedge clk_i) disable iff (por_i)
    test_mode_o |-> ($past(tst_pin_i) == ACT));

  always_comb begin
    if (por_i) begin
      p_por_quiet_r7: assert (!boot_start_o && !user_start_o && !test_mode_o);
    end
  end
endmodule

bind boot_entry_detect be_checker #(.VARIANT(VARIANT)) u_chk (
  .clk_i        (clk_i),
  .por_i        (por_i),
  .rst_pin_i    (rst_pin_i),
  .tst_pin_i    (tst_pin_i),
  .dbg_own_i    (dbg_own_i),
  .nmi_mode_i   (nmi_mode_i),
  .boot_start_o (boot_start_o),
  .user_start_o (user_start_o),
  .test_mode_o  (test_mode_o)
);

// File: tb/test_boot_entry_detect.sv
`timescale 1ns/1ps
module test_boot_entry_detect;
  import boot_entry_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por, rst_pin, tst, dbg, nmi;
  logic tst_f;
  logic br, ur, tr, bf, uf, tf;

  assign tst_f = ~tst;

  boot_entry_detect #(.VARIANT(EDGE_RISE)) i_boot_entry_detect (
    .clk_i(clk), .por_i(por), .rst_pin_i(rst_pin), .tst_pin_i(tst),
    .dbg_own_i(dbg), .nmi_mode_i(nmi),
    .boot_start_o(br), .user_start_o(ur), .test_mode_o(tr));

  // Falling variant, driven with the mirrored pin: same expected results.
  boot_entry_detect #(.VARIANT(EDGE_FALL)) i_boot_entry_detect_fall (
    .clk_i(clk), .por_i(por), .rst_pin_i(rst_pin), .tst_pin_i(tst_f),
    .dbg_own_i(dbg), .nmi_mode_i(nmi),
    .boot_start_o(bf), .user_start_o(uf), .test_mode_o(tf));

  typedef struct {
    bit    boot;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: pops one expected decision per observed pulse.
  always @(negedge clk) begin
    if (!por && (br || ur || bf || uf)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "pulse with no release pending", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(br == e.boot && ur == !e.boot, e.req, "rising decision {boot,user}",
              {30'd0, br, ur}, {30'd0, e.boot, !e.boot});
        check(bf == e.boot && uf == !e.boot, {"R2/", e.req}, "falling decision {boot,user}",
              {30'd0, bf, uf}, {30'd0, e.boot, !e.boot});
      end
    end
  end

  task automatic release_and_check(bit exp_boot, string req);
    exp_q.push_back('{exp_boot, req});
    rst_pin = 1'b1;
    tick();
    #1;
    check(exp_q.size() == 0, "R8", "pulse in cycle after release", exp_q.size(), 0);
    tick();
    #1;
    check(!(br || ur || bf || uf), "R8", "pulse lasts one cycle",
          {28'd0, br, ur, bf, uf}, 0);
  endtask

  task automatic session(int edges, bit lvl, bit d, bit m, bit exp_boot, string req);
    tst = (edges == 0) ? lvl : 1'b0;
    tick();
    rst_pin = 1'b0;
    tick();
    for (int i = 0; i < edges; i++) begin
      tst = 1'b1;
      tick();
      if (i != edges - 1 || !lvl) begin
        tst = 1'b0;
        tick();
      end
    end
    dbg = d;
    nmi = m;
    tick();
    release_and_check(exp_boot, req);
    dbg = 1'b0;
    nmi = 1'b0;
    tick();
  endtask

  task automatic check_tm(bit exp, string what);
    check(tr == exp, "R10", {"rising ", what}, tr, exp);
    check(tf == exp, "R10", {"falling ", what}, tf, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R8", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    por = 1'b1; rst_pin = 1'b1; tst = 1'b0; dbg = 1'b0; nmi = 1'b0;
    tick(3);
    check({br, ur, tr, bf, uf, tf} == 6'd0, "R7", "outputs during power-on reset",
          {br, ur, tr, bf, uf, tf}, 0);
    por = 1'b0;
    tick(4);
    check(!(br || ur || bf || uf), "R7", "no decision with reset pin never low",
          {br, ur, bf, uf}, 0);

    // Main entry, both variants
    session(2, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
    session(3, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
    // Saturation
    session(6, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
    // Too few edges
    session(1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    session(0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    // Inactive level at release
    session(2, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    session(4, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    // Inhibits
    session(2, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    session(2, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    session(2, 1'b1, 1'b0, 1'b0, 1'b1, "R1");

    // Edges while reset high do not count
    rst_pin = 1'b1;
    tst = 1'b0; tick(); tst = 1'b1; tick(); tst = 1'b0; tick(); tst = 1'b1; tick();
    rst_pin = 1'b0; tick(2);
    release_and_check(1'b0, "R9");
    tick();

    // Test-mode level
    tst = 1'b0; tick();
    rst_pin = 1'b0; tick();
    check_tm(1'b0, "inactive pin");
    tst = 1'b1; tick();
    check_tm(1'b1, "after first edge");
    tst = 1'b0; tick();
    check_tm(1'b0, "pin inactive again");
    tst = 1'b1; tick();
    check_tm(1'b0, "forced low after final edge");
    tick(2);
    check_tm(1'b0, "held low while reset low");
    exp_q.push_back('{1'b1, "R10"});
    rst_pin = 1'b1; tick();
    check_tm(1'b1, "restored after release");
    tick(2);

    // Edges during power-on reset are discarded
    tst = 1'b0; rst_pin = 1'b0; tick();
    por = 1'b1; tick();
    tst = 1'b1; tick(); tst = 1'b0; tick(); tst = 1'b1; tick(); tst = 1'b0; tick();
    tst = 1'b1; tick();
    por = 1'b0; tick(2);
    release_and_check(1'b0, "R7");
    tick(2);

    check(exp_q.size() == 0, "R8", "all expected decisions seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule